// File: doc/BRIEF.md
# Static Branch Resolution Scanner

This block looks at every slot of an eight-deep queue of decoded instructions waiting for dispatch. Each cycle it picks the oldest slot that holds a valid branch. For that branch it forms the destination address and predicts the direction. The prediction uses fixed rules only, and no history is stored. An unconditional branch is always taken. A conditional branch whose condition field is already known follows that field. A conditional branch whose field is still pending is guessed from the sign of its displacement.

The result is registered and appears one clock after the queue contents it describes. It carries a found flag, the slot index, the destination address, the predicted direction, and a flag that tells a resolved outcome apart from a guess. Slot contents come in as flattened vectors, slot 0 in the lowest bits. The condition-code state comes in as one flag bit per field plus a matching known bit per field.

Top module: `sbr_scan`

## Requirements
- R1: Among the ENTRIES slots, the lowest-indexed slot with both valid and branch set is selected, and its index appears on `hit_idx_o`. Slots with only one of the two bits set are ignored.
- R2: `hit_target_o` equals the selected slot's PC plus its displacement, sign-extended from DISP_W bits (bit DISP_W-1 is the sign), modulo 2^ADDR_W.
- R3: A selected branch with its conditional bit at 0 gives taken=1 and resolved=1.
- R4: A selected conditional branch whose chosen field has its known bit at 1 gives resolved=1. It gives taken=1 exactly when that field's flag bit equals the slot's sense bit.
- R5: A selected conditional branch whose chosen field has its known bit at 0, with a displacement whose sign bit is 1 (backward), gives taken=1 and resolved=0.
- R6: A selected conditional branch whose chosen field has its known bit at 0, with a displacement whose sign bit is 0 (forward or zero), gives taken=0 and resolved=0.
- R7: When no slot has both valid and branch set, `hit_o` is 0 and the index, target, taken and resolved outputs are all 0.
- R8: All outputs are registered. They reflect the inputs present at the previous rising clock edge, and an active-low reset clears them all to 0.
- R9: The result depends only on the current inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ent_valid_i | input | ENTRIES | Slot holds a decoded instruction |
| ent_branch_i | input | ENTRIES | Slot instruction is a branch |
| ent_cond_i | input | ENTRIES | Branch is conditional |
| ent_sense_i | input | ENTRIES | Flag value for which the conditional branch is taken |
| ent_pc_i | input | ENTRIES*ADDR_W | Per-slot instruction address |
| ent_disp_i | input | ENTRIES*DISP_W | Per-slot signed displacement |
| ent_ccsel_i | input | ENTRIES*SEL_W | Per-slot condition field selector |
| cc_flag_i | input | CC_FIELDS | Flag bit of each condition field |
| cc_known_i | input | CC_FIELDS | Condition field value is available |
| hit_o | output | 1 | A branch was found |
| hit_idx_o | output | IDX_W | Index of the selected slot |
| hit_target_o | output | ADDR_W | Destination address |
| hit_taken_o | output | 1 | Predicted or resolved direction |
| hit_resolved_o | output | 1 | 1 when the direction comes from a known condition, 0 when guessed |

## Verification
Slot selection and direction rules act in the same cycle. The bench therefore loads the queue with several branches at once. Typical mixes pair an older branch whose field is pending with a younger unconditional one, or an older resolved branch with a younger backward guess. It then checks that the index, target and direction all come from the older slot. A further case keeps an unrelated field known while the selected field is pending. Repeating an early stimulus late in the run shows that the outcome carries no memory of the traffic in between.

// File: rtl/sbr_pkg.sv
`timescale 1ns/1ps
package sbr_pkg;

   typedef struct packed {
      logic taken;
      logic resolved;
   } sbr_dir_t;

   localparam sbr_dir_t SBR_DIR_NONE = '{taken: 1'b0, resolved: 1'b0};

endpackage

// File: rtl/sbr_oldest_pick.sv
`timescale 1ns/1ps
module sbr_oldest_pick #(
   parameter int N    = 8,
   parameter int IW   = $clog2(N)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [N-1:0]  req_i,
   output logic          found_o,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o
);

   logic [N:0] lower_any;

   assign lower_any[0] = 1'b0;

   for (genvar g = 0; g < N; g++) begin : g_chain
      assign grant_o[g]     = req_i[g] & ~lower_any[g];
      assign lower_any[g+1] = lower_any[g] | req_i[g];
   end

   assign found_o = lower_any[N];

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (grant_o[i]) idx_o = idx_o | IW'(i);
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o)) else $error("more than one slot granted"); // R1

   AST_GRANT_IS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      found_o |-> req_i[idx_o]) else $error("granted slot not requesting"); // R1

endmodule

// File: rtl/sbr_target_gen.sv
`timescale 1ns/1ps
module sbr_target_gen #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] target_o
);

   logic [ADDR_W-1:0] disp_ext;

   if (DISP_W == ADDR_W) begin : g_full
      assign disp_ext = disp_i;
   end else begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
   end

   assign target_o = pc_i + disp_ext;

endmodule

// File: rtl/sbr_dir_rule.sv
`timescale 1ns/1ps
module sbr_dir_rule
   import sbr_pkg::*;
(
   input  logic     is_cond_i,
   input  logic     sense_i,
   input  logic     flag_i,
   input  logic     known_i,
   input  logic     backward_i,
   output sbr_dir_t dir_o
);

   always_comb begin
      if (!is_cond_i) begin
         dir_o.taken    = 1'b1;
         dir_o.resolved = 1'b1;
      end else if (known_i) begin
         dir_o.taken    = (flag_i == sense_i);
         dir_o.resolved = 1'b1;
      end else begin
         dir_o.taken    = backward_i;
         dir_o.resolved = 1'b0;
      end
   end

endmodule

// File: rtl/sbr_scan.sv
`timescale 1ns/1ps
module sbr_scan
   import sbr_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int ADDR_W    = 32,
   parameter int DISP_W    = 16,
   parameter int CC_FIELDS = 8,
   parameter int SEL_W     = $clog2(CC_FIELDS),
   parameter int IDX_W     = $clog2(ENTRIES)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [ENTRIES-1:0]        ent_valid_i,
   input  logic [ENTRIES-1:0]        ent_branch_i,
   input  logic [ENTRIES-1:0]        ent_cond_i,
   input  logic [ENTRIES-1:0]        ent_sense_i,
   input  logic [ENTRIES*ADDR_W-1:0] ent_pc_i,
   input  logic [ENTRIES*DISP_W-1:0] ent_disp_i,
   input  logic [ENTRIES*SEL_W-1:0]  ent_ccsel_i,
   input  logic [CC_FIELDS-1:0]      cc_flag_i,
   input  logic [CC_FIELDS-1:0]      cc_known_i,
   output logic                      hit_o,
   output logic [IDX_W-1:0]          hit_idx_o,
   output logic [ADDR_W-1:0]         hit_target_o,
   output logic                      hit_taken_o,
   output logic                      hit_resolved_o
);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (DISP_W < 2 || DISP_W > ADDR_W) begin : g_bad_disp
      $error("DISP_W must lie in 2..ADDR_W");
   end
   if (CC_FIELDS < 2 || (1 << SEL_W) != CC_FIELDS) begin : g_bad_cc
      $error("CC_FIELDS must be a power of two, at least 2");
   end
   if ((1 << IDX_W) < ENTRIES) begin : g_bad_idx
      $error("IDX_W too narrow for ENTRIES");
   end

   // slot qualification and oldest pick
   logic [ENTRIES-1:0] slot_req;
   logic [ENTRIES-1:0] grant;
   logic               pick_found;
   logic [IDX_W-1:0]   pick_idx;

   assign slot_req = ent_valid_i & ent_branch_i;

   sbr_oldest_pick #(
      .N  (ENTRIES),
      .IW (IDX_W)
   ) i_pick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (slot_req),
      .found_o (pick_found),
      .grant_o (grant),
      .idx_o   (pick_idx)
   );

   // one-hot AND-OR select of the winning slot's fields
   logic [ADDR_W-1:0] sel_pc;
   logic [DISP_W-1:0] sel_disp;
   logic [SEL_W-1:0]  sel_ccsel;
   logic              sel_cond;
   logic              sel_sense;

   always_comb begin
      sel_pc    = '0;
      sel_disp  = '0;
      sel_ccsel = '0;
      sel_cond  = 1'b0;
      sel_sense = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (grant[i]) begin
            sel_pc    = sel_pc    | ent_pc_i[i*ADDR_W +: ADDR_W];
            sel_disp  = sel_disp  | ent_disp_i[i*DISP_W +: DISP_W];
            sel_ccsel = sel_ccsel | ent_ccsel_i[i*SEL_W +: SEL_W];
            sel_cond  = sel_cond  | ent_cond_i[i];
            sel_sense = sel_sense | ent_sense_i[i];
         end
      end
   end

   // target address
   logic [ADDR_W-1:0] tgt_next;

   sbr_target_gen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) i_target (
      .pc_i     (sel_pc),
      .disp_i   (sel_disp),
      .target_o (tgt_next)
   );

   // direction rule
   sbr_dir_t dir_next;
   logic     sel_flag;
   logic     sel_known;

   assign sel_flag  = cc_flag_i[sel_ccsel];
   assign sel_known = cc_known_i[sel_ccsel];

   sbr_dir_rule i_rule (
      .is_cond_i  (sel_cond),
      .sense_i    (sel_sense),
      .flag_i     (sel_flag),
      .known_i    (sel_known),
      .backward_i (sel_disp[DISP_W-1]),
      .dir_o      (dir_next)
   );

   // output register: loads on a find, clears when idle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hit_o          <= 1'b0;
         hit_idx_o      <= '0;
         hit_target_o   <= '0;
         hit_taken_o    <= 1'b0;
         hit_resolved_o <= 1'b0;
      end else if (pick_found) begin
         hit_o          <= 1'b1;
         hit_idx_o      <= pick_idx;
         hit_target_o   <= tgt_next;
         hit_taken_o    <= dir_next.taken;
         hit_resolved_o <= dir_next.resolved;
      end else begin
         hit_o          <= 1'b0;
         hit_idx_o      <= '0;
         hit_target_o   <= '0;
         hit_taken_o    <= SBR_DIR_NONE.taken;
         hit_resolved_o <= SBR_DIR_NONE.resolved;
      end
   end

   AST_FOUND_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pick_found |=> hit_o) else $error("branch present but no hit"); // R1

   AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit_o |-> (hit_idx_o == '0 && hit_target_o == '0 && !hit_taken_o && !hit_resolved_o))
      else $error("idle outputs not cleared"); // R7

   AST_UNCOND_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pick_found && !sel_cond) |=> (hit_taken_o && hit_resolved_o))
      else $error("unconditional branch not taken/resolved"); // R3

   AST_GUESS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pick_found && sel_cond && !sel_known) |=> (!hit_resolved_o && hit_taken_o == $past(sel_disp[DISP_W-1])))
      else $error("guess does not follow displacement sign"); // R5

   AST_KNOWN_RESOLVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pick_found && sel_cond && sel_known) |=> hit_resolved_o)
      else $error("known condition not marked resolved"); // R4

endmodule

// File: tb/test_sbr_scan.sv
`timescale 1ns/1ps
module test_sbr_scan;

   localparam int CLK_PERIOD = 10;
   localparam int ENTRIES    = 8;
   localparam int ADDR_W     = 32;
   localparam int DISP_W     = 16;
   localparam int CC_FIELDS  = 8;
   localparam int SEL_W      = $clog2(CC_FIELDS);
   localparam int IDX_W      = $clog2(ENTRIES);

   typedef struct {
      logic              hit;
      logic [IDX_W-1:0]  idx;
      logic [ADDR_W-1:0] target;
      logic              taken;
      logic              resolved;
      string             tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic [ENTRIES-1:0] tb_v, tb_b, tb_c, tb_s;
   logic [ADDR_W-1:0]  tb_pc   [ENTRIES];
   logic [DISP_W-1:0]  tb_disp [ENTRIES];
   logic [SEL_W-1:0]   tb_sel  [ENTRIES];
   logic [CC_FIELDS-1:0] tb_flag, tb_known;

   logic [ENTRIES*ADDR_W-1:0] pc_flat;
   logic [ENTRIES*DISP_W-1:0] disp_flat;
   logic [ENTRIES*SEL_W-1:0]  sel_flat;

   logic              hit, taken, resolved;
   logic [IDX_W-1:0]  idx;
   logic [ADDR_W-1:0] target;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         pc_flat[i*ADDR_W +: ADDR_W]  = tb_pc[i];
         disp_flat[i*DISP_W +: DISP_W] = tb_disp[i];
         sel_flat[i*SEL_W +: SEL_W]    = tb_sel[i];
      end
   end

   sbr_scan #(
      .ENTRIES   (ENTRIES),
      .ADDR_W    (ADDR_W),
      .DISP_W    (DISP_W),
      .CC_FIELDS (CC_FIELDS)
   ) i_sbr_scan (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .ent_valid_i    (tb_v),
      .ent_branch_i   (tb_b),
      .ent_cond_i     (tb_c),
      .ent_sense_i    (tb_s),
      .ent_pc_i       (pc_flat),
      .ent_disp_i     (disp_flat),
      .ent_ccsel_i    (sel_flat),
      .cc_flag_i      (tb_flag),
      .cc_known_i     (tb_known),
      .hit_o          (hit),
      .hit_idx_o      (idx),
      .hit_target_o   (target),
      .hit_taken_o    (taken),
      .hit_resolved_o (resolved)
   );

   // reference model written from the requirements
   function automatic exp_t model(string tag);
      exp_t e;
      e.hit = 0; e.idx = '0; e.target = '0; e.taken = 0; e.resolved = 0; e.tag = tag;
      for (int i = 0; i < ENTRIES; i++) begin
         if (tb_v[i] && tb_b[i]) begin
            logic signed [ADDR_W-1:0] d;
            d = ADDR_W'($signed(tb_disp[i]));
            e.hit = 1;
            e.idx = IDX_W'(i);
            e.target = tb_pc[i] + d;
            if (!tb_c[i]) begin
               e.taken = 1; e.resolved = 1;
            end else if (tb_known[tb_sel[i]]) begin
               e.taken = (tb_flag[tb_sel[i]] == tb_s[i]); e.resolved = 1;
            end else begin
               e.taken = tb_disp[i][DISP_W-1]; e.resolved = 0;
            end
            break;
         end
      end
      return e;
   endfunction

   task automatic clear_all();
      tb_v = '0; tb_b = '0; tb_c = '0; tb_s = '0;
      tb_flag = '0; tb_known = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         tb_pc[i]   = 32'h1000 + 32'(i * 4);
         tb_disp[i] = 16'h0040;
         tb_sel[i]  = '0;
      end
   endtask

   task automatic set_slot(int i, bit v, bit b, bit c, bit s,
                           logic [ADDR_W-1:0] pc, logic [DISP_W-1:0] d,
                           logic [SEL_W-1:0] sel);
      tb_v[i] = v; tb_b[i] = b; tb_c[i] = c; tb_s[i] = s;
      tb_pc[i] = pc; tb_disp[i] = d; tb_sel[i] = sel;
   endtask

   // driver: the inputs stand from this negedge; the result is due after the next posedge
   task automatic apply(string tag);
      @(negedge clk);
      sb_q.push_back(model(tag));
      @(posedge clk);
      #2;
   endtask

   // monitor: pops one expected item per clock edge while items wait
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (hit !== e.hit || idx !== e.idx || target !== e.target ||
             taken !== e.taken || resolved !== e.resolved) begin
            failures++;
            $display("FAIL %s: got hit=%0b idx=%0d tgt=%h tk=%0b rs=%0b exp hit=%0b idx=%0d tgt=%h tk=%0b rs=%0b",
                     e.tag, hit, idx, target, taken, resolved,
                     e.hit, e.idx, e.target, e.taken, e.resolved);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      clear_all();
      set_slot(3, 1, 1, 0, 0, 32'h2000, 16'h0010, 0);
      repeat (3) @(posedge clk);
      #1;
      checks++; // R8 reset state
      if (hit !== 0 || idx !== 0 || target !== 0 || taken !== 0 || resolved !== 0) begin
         failures++;
         $display("FAIL R8 reset: got hit=%0b tgt=%h exp all zero", hit, target);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #2;

      // R7: empty queue
      clear_all();
      apply("R7 empty");

      // R1/R7: qualifying bits split across slots
      clear_all();
      set_slot(1, 1, 0, 0, 0, 32'h100, 16'h0004, 0);
      set_slot(4, 0, 1, 0, 0, 32'h200, 16'h0004, 0);
      apply("R1 R7 partial bits ignored");

      // R3 R2: unconditional at slot 5
      clear_all();
      set_slot(5, 1, 1, 0, 0, 32'h0000_3000, 16'h0120, 0);
      apply("R3 R2 uncond fwd");

      // R4: known, flag equals sense
      clear_all();
      set_slot(0, 1, 1, 1, 1, 32'h400, 16'hFFF0, 3'd2);
      tb_flag[2] = 1; tb_known[2] = 1;
      apply("R4 known match taken");

      // R4: known, flag differs from sense (backward disp must not matter)
      tb_flag[2] = 0;
      apply("R4 known mismatch not taken");

      // R4: sense 0 with flag 0
      tb_s[0] = 0;
      apply("R4 sense0 flag0 taken");

      // R5: pending field, backward
      clear_all();
      set_slot(2, 1, 1, 1, 1, 32'h800, 16'hFF80, 3'd5);
      tb_known[4] = 1; tb_flag[4] = 1;
      apply("R5 pending backward guessed taken");

      // R6: pending field, zero displacement
      clear_all();
      set_slot(6, 1, 1, 1, 0, 32'h900, 16'h0000, 3'd1);
      apply("R6 pending zero disp not taken");

      // R6: pending, forward
      tb_disp[6] = 16'h7FFF;
      apply("R6 pending forward not taken");

      // R1: older pending conditional vs younger unconditional
      clear_all();
      set_slot(2, 1, 1, 1, 0, 32'hA00, 16'h0020, 3'd3);
      set_slot(6, 1, 1, 0, 0, 32'hB00, 16'h0008, 0);
      apply("R1 oldest wins over younger uncond");

      // R1: older resolved vs younger backward guess, plus last slot alone
      clear_all();
      set_slot(3, 1, 1, 1, 1, 32'hC00, 16'h0030, 3'd7);
      set_slot(4, 1, 1, 1, 0, 32'hD00, 16'hFFFC, 3'd0);
      tb_known[7] = 1; tb_flag[7] = 1;
      apply("R1 oldest resolved vs younger guess");
      clear_all();
      set_slot(7, 1, 1, 0, 0, 32'hE00, 16'h0002, 0);
      apply("R1 last slot");

      // R2: wraparound both ways
      clear_all();
      set_slot(0, 1, 1, 0, 0, 32'hFFFF_FFF0, 16'h0020, 0);
      apply("R2 wrap up");
      clear_all();
      set_slot(1, 1, 1, 0, 0, 32'h0000_0010, 16'hFFE0, 0);
      apply("R2 wrap down");

      // R8: found / idle alternation, one result per cycle
      clear_all();
      set_slot(2, 1, 1, 0, 0, 32'h1234, 16'h0010, 0);
      apply("R8 alt found");
      clear_all();
      apply("R8 alt idle");
      set_slot(2, 1, 1, 0, 0, 32'h1234, 16'h0010, 0);
      apply("R8 alt found again");

      // R9: repeat the earlier backward-guess stimulus
      clear_all();
      set_slot(2, 1, 1, 1, 1, 32'h800, 16'hFF80, 3'd5);
      tb_known[4] = 1; tb_flag[4] = 1;
      apply("R9 repeat gives same result");

      clear_all();
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule